// File: doc/BRIEF.md
# Dual Address Pointer Unit

This block keeps two 16-bit external-memory address pointers and presents whichever one is active on a 16-bit address output. A core drives single-cycle operation strobes into it: load an immediate value, increment, memory read access and memory write access. Software reaches each pointer byte and a small control register through a byte-wide register port.

The control register sets which pointer is active. It can make the active pointer flip after every pointer operation. It can also make a memory access step the pointer it used, up or down as set by a per-pointer direction bit. A copy loop can then alternate source and destination pointers with no software bookkeeping. Load both pointers with two back-to-back loads, then issue read, write, read, write and so on.

Top module: `dual_dptr`

## Requirements
- R1: After reset both pointers are 0000h, the control register is 00h and `mem_addr` is 0000h.
- R2: Register port addresses are 0 = pointer 0 low byte, 1 = pointer 0 high byte, 2 = pointer 1 low byte, 3 = pointer 1 high byte, 4 = control. A write takes effect at the next clock edge. A read is combinational and returns the stored byte whichever pointer is active. Any other address reads 00h.
- R3: The control bits are: bit 0 active select (0 = pointer 0), bit 4 auto-advance enable, bit 5 auto-toggle enable, bit 6 pointer 0 direction, bit 7 pointer 1 direction (1 = decrement). Bits 1 to 3 always read 0. `mem_addr` always shows the active pointer.
- R4: A load strobe writes `op_imm` into the active pointer. With toggle off, the select bit is unchanged.
- R5: With toggle on, each load, increment, read or write strobe flips the select bit at the same edge. Two consecutive loads therefore fill pointer 0 and then pointer 1.
- R6: With auto-advance on and the direction bit clear, a read or write access increments the pointer it used. `mem_addr` shows that pointer during the access, and the step lands at the same edge as the toggle.
- R7: With the direction bit set, an auto-advance decrements instead. Both directions wrap modulo 2^16.
- R8: With auto-advance off, read and write accesses leave both pointers unchanged. Toggle still applies.
- R9: An increment strobe adds one to the active pointer whatever the auto-advance and direction bits say.
- R10: When several requests arrive in one cycle, only the highest acts. The order is load, then increment, then access, then register-port write. The others are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_load | input | 1 | Load active pointer from `op_imm` |
| op_imm | input | 16 | Immediate value for a load |
| op_inc | input | 1 | Increment active pointer |
| op_rd | input | 1 | Memory read access using the active pointer |
| op_wr | input | 1 | Memory write access using the active pointer |
| mem_addr | output | 16 | Active pointer value |
| sfr_addr | input | 3 | Register port address |
| sfr_we | input | 1 | Register port write enable |
| sfr_wdata | input | 8 | Register port write data |
| sfr_rdata | output | 8 | Register port read data |

## Verification
The bench runs a copy sequence and samples `mem_addr` during each access. This catches a design that advances the pointer before it is used, or that steps the other pointer after the toggle. Pointers are forced to 0000h and FFFFh to expose missing wrap or a decrement that ignores the direction bit. Simultaneous strobes are sent, including an access paired with a port write, to catch a priority inversion that double-steps or overwrites a pointer byte. Reading pointer 1 while pointer 0 is active catches a read path that follows the select bit instead of the address.

// File: rtl/dual_dptr.sv
module dual_dptr #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_load,
  input  logic [2*BW-1:0] op_imm,
  input  logic            op_inc,
  input  logic            op_rd,
  input  logic            op_wr,
  output logic [2*BW-1:0] mem_addr,
  input  logic [2:0]      sfr_addr,
  input  logic            sfr_we,
  input  logic [BW-1:0]   sfr_wdata,
  output logic [BW-1:0]   sfr_rdata
);
  localparam int AW = 2 * BW;

  logic [AW-1:0] ptr [2];
  logic [7:0]    ctrl;

  logic sel, adv_en, tog_en;
  assign sel    = ctrl[0];
  assign adv_en = ctrl[4];
  assign tog_en = ctrl[5];

  logic          access, any_op, dir;
  logic [AW-1:0] act, step;
  assign access   = op_rd | op_wr;
  assign any_op   = op_load | op_inc | access;
  assign act      = ptr[sel];
  assign dir      = sel ? ctrl[7] : ctrl[6];
  assign step     = dir ? {AW{1'b1}} : AW'(1);
  assign mem_addr = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr[0] <= '0;
      ptr[1] <= '0;
      ctrl   <= '0;
    end else begin
      if (op_load)
        ptr[sel] <= op_imm;
      else if (op_inc)
        ptr[sel] <= act + AW'(1);
      else if (access) begin
        if (adv_en) ptr[sel] <= act + step;
      end else if (sfr_we) begin
        case (sfr_addr)
          3'd0: ptr[0][BW-1:0]  <= sfr_wdata;
          3'd1: ptr[0][AW-1:BW] <= sfr_wdata;
          3'd2: ptr[1][BW-1:0]  <= sfr_wdata;
          3'd3: ptr[1][AW-1:BW] <= sfr_wdata;
          3'd4: ctrl            <= 8'(sfr_wdata) & 8'hF1;
          default: ;
        endcase
      end
      if (any_op && tog_en) ctrl[0] <= ~sel;
    end
  end

  always_comb begin
    case (sfr_addr)
      3'd0:    sfr_rdata = ptr[0][BW-1:0];
      3'd1:    sfr_rdata = ptr[0][AW-1:BW];
      3'd2:    sfr_rdata = ptr[1][BW-1:0];
      3'd3:    sfr_rdata = ptr[1][AW-1:BW];
      3'd4:    sfr_rdata = BW'(ctrl);
      default: sfr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_dptr_chk.sv
module dual_dptr_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_load,
  input logic [AW-1:0] op_imm,
  input logic          op_inc,
  input logic          op_rd,
  input logic          op_wr,
  input logic          sfr_we,
  input logic [AW-1:0] p0,
  input logic [AW-1:0] p1,
  input logic [7:0]    ctrl
);
  logic anyop, acc_only;
  assign anyop    = op_load | op_inc | op_rd | op_wr;
  assign acc_only = !op_load && !op_inc && (op_rd || op_wr);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_load |=> (($past(ctrl[0]) ? p1 : p0) == $past(op_imm)));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (anyop && ctrl[5]) |=> (ctrl[0] != $past(ctrl[0])));

  assert_keep_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (anyop && !ctrl[5]) |=> (ctrl[0] == $past(ctrl[0])));

  assert_adv_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_only && ctrl[4] && !ctrl[0] && !ctrl[6]) |=> (p0 == $past(p0) + AW'(1)));

  assert_adv_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_only && ctrl[4] && !ctrl[0] && ctrl[6]) |=> (p0 == $past(p0) - AW'(1)));

  assert_no_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_only && !ctrl[4]) |=> ($stable(p0) && $stable(p1)));

  assert_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_load && op_inc && !ctrl[0]) |=> (p0 == $past(p0) + AW'(1)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyop && !sfr_we) |=> ($stable(p0) && $stable(p1) && $stable(ctrl)));
endmodule

bind dual_dptr dual_dptr_chk #(.AW(2*BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_load(op_load), .op_imm(op_imm),
  .op_inc(op_inc), .op_rd(op_rd), .op_wr(op_wr), .sfr_we(sfr_we),
  .p0(ptr[0]), .p1(ptr[1]), .ctrl(ctrl)
);

// File: tb/tb_dual_dptr.sv
`timescale 1ns/100ps
module tb_dual_dptr;
  logic        clk = 0, rst_n = 0;
  logic        op_load = 0, op_inc = 0, op_rd = 0, op_wr = 0, sfr_we = 0;
  logic [15:0] op_imm = 0, mem_addr;
  logic [2:0]  sfr_addr = 0;
  logic [7:0]  sfr_wdata = 0, sfr_rdata;
  int checks = 0, errors = 0;
  logic [15:0] seen;

  always #2.5 clk = ~clk;

  dual_dptr dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_we = 1;
    @(negedge clk); sfr_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    sfr_addr = a; #1; d = sfr_rdata;
  endtask

  task automatic ptr(input bit which, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(which ? 3'd2 : 3'd0, lo);
    rd(which ? 3'd3 : 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setp(input bit which, input logic [15:0] v);
    wr(which ? 3'd2 : 3'd0, v[7:0]);
    wr(which ? 3'd3 : 3'd1, v[15:8]);
  endtask

  task automatic pulse(input bit ld, input bit inc, input bit r, input bit w,
                       input logic [15:0] imm, input bit we = 0,
                       input logic [2:0] a = 0, input logic [7:0] d = 0);
    @(negedge clk);
    op_load = ld; op_inc = inc; op_rd = r; op_wr = w; op_imm = imm;
    sfr_we = we; sfr_addr = a; sfr_wdata = d;
    #1 seen = mem_addr;
    @(negedge clk);
    op_load = 0; op_inc = 0; op_rd = 0; op_wr = 0; sfr_we = 0;
  endtask

  logic [15:0] v;
  logic [7:0]  b;

  task automatic t_reset;
    ptr(0, v); chk("R1 p0", v, 16'h0000);
    ptr(1, v); chk("R1 p1", v, 16'h0000);
    rd(3'd4, b); chk("R1 ctrl", {8'h0, b}, 16'h0000);
    chk("R1 mem_addr", mem_addr, 16'h0000);
  endtask

  task automatic t_port;
    setp(0, 16'h1234); setp(1, 16'hABCD);
    ptr(0, v); chk("R2 p0 readback", v, 16'h1234);
    ptr(1, v); chk("R2 p1 read while p0 active", v, 16'hABCD);
    rd(3'd5, b); chk("R2 unused address", {8'h0, b}, 16'h0000);
    chk("R3 mem_addr p0", mem_addr, 16'h1234);
  endtask

  task automatic t_ctrl;
    wr(3'd4, 8'hFF);
    rd(3'd4, b); chk("R3 ctrl readback", {8'h0, b}, 16'h00F1);
    chk("R3 mem_addr p1", mem_addr, 16'hABCD);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_load;
    pulse(1, 0, 0, 0, 16'h5555);
    ptr(0, v); chk("R4 load p0", v, 16'h5555);
    rd(3'd4, b); chk("R4 sel kept", {8'h0, b}, 16'h0000);
    wr(3'd4, 8'h01);
    pulse(1, 0, 0, 0, 16'h6666);
    ptr(1, v); chk("R4 load p1", v, 16'h6666);
    ptr(0, v); chk("R4 p0 untouched", v, 16'h5555);
  endtask

  task automatic t_toggle_load;
    wr(3'd4, 8'h20);
    pulse(1, 0, 0, 0, 16'h0100);
    pulse(1, 0, 0, 0, 16'h0200);
    ptr(0, v); chk("R5 first load p0", v, 16'h0100);
    ptr(1, v); chk("R5 second load p1", v, 16'h0200);
    rd(3'd4, b); chk("R5 sel back to 0", {8'h0, b}, 16'h0020);
  endtask

  task automatic t_copy;
    wr(3'd4, 8'h30);
    pulse(0, 0, 1, 0, 0); chk("R6 read addr 1", seen, 16'h0100);
    pulse(0, 0, 0, 1, 0); chk("R6 write addr 1", seen, 16'h0200);
    pulse(0, 0, 1, 0, 0); chk("R6 read addr 2", seen, 16'h0101);
    pulse(0, 0, 0, 1, 0); chk("R6 write addr 2", seen, 16'h0201);
    ptr(0, v); chk("R6 p0 final", v, 16'h0102);
    ptr(1, v); chk("R6 p1 final", v, 16'h0202);
  endtask

  task automatic t_dir;
    setp(0, 16'h0000); setp(1, 16'hFFFF);
    wr(3'd4, 8'h70);
    pulse(0, 0, 1, 0, 0);
    ptr(0, v); chk("R7 decrement wrap", v, 16'hFFFF);
    pulse(0, 0, 0, 1, 0);
    ptr(1, v); chk("R7 increment wrap", v, 16'h0000);
  endtask

  task automatic t_noadv;
    wr(3'd4, 8'h20);
    pulse(0, 0, 1, 0, 0);
    ptr(0, v); chk("R8 p0 held", v, 16'hFFFF);
    rd(3'd4, b); chk("R8 toggle still", {8'h0, b}, 16'h0021);
    pulse(0, 0, 0, 1, 0);
    ptr(1, v); chk("R8 p1 held", v, 16'h0000);
  endtask

  task automatic t_inc;
    wr(3'd4, 8'h40);
    pulse(0, 1, 0, 0, 0);
    ptr(0, v); chk("R9 inc ignores dir and adv", v, 16'h0000);
    rd(3'd4, b); chk("R9 no toggle", {8'h0, b}, 16'h0040);
  endtask

  task automatic t_prio;
    wr(3'd4, 8'h10);
    pulse(1, 1, 0, 0, 16'h3000);
    ptr(0, v); chk("R10 load beats inc", v, 16'h3000);
    pulse(0, 1, 1, 0, 0);
    ptr(0, v); chk("R10 inc beats access", v, 16'h3001);
    pulse(0, 0, 1, 0, 0, 1, 3'd0, 8'h77);
    ptr(0, v); chk("R10 access beats port write", v, 16'h3002);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset(); t_port(); t_ctrl(); t_load(); t_toggle_load();
    t_copy(); t_dir(); t_noadv(); t_inc(); t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule